// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the horizontal and vertical timing of a standard-definition interlaced raster. It is advanced by a pixel-clock enable. A frame is two fields. Each field has its own vertical settings: active lines, front porch, sync width and back porch. Both fields share one horizontal setting: active pixels, front porch, sync width and back porch. A line starts with its active pixels, then its front porch, then the sync pulse, then the back porch. A field is laid out the same way in lines.

The outputs are active-low horizontal and vertical sync, an active-video flag, a field-parity indicator, the pixel and line counters, and a window flag in the horizontal back porch where a colour burst may be placed. A typical NTSC-like setting is 720/14/64/60 horizontally with 3/3/16 porches and sync in both fields, odd field first. A PAL-like setting is 720/20/64/60 with 288 active lines per field, 2/3/20 and 2/3/19, even field first.

Settings are captured during reset and again only at the frame boundary. A change made while a frame is running therefore leaves that frame untouched.

Top module: `ilace_vtg`

## Requirements
- R1: While `rst_n` is low, the following hold at the first sample after a clock edge: `hcount` and `vcount` are 0, `hsync_n` is 1, the first field is selected, and `field_odd` equals `cfg_first_odd`. The settings present on the inputs are captured.
- R2: `hcount` advances by one on every clock edge with `pix_ce` high. It wraps to 0 after reaching active+front+sync+back−1. It holds its value when `pix_ce` is low.
- R3: `hsync_n` is 0 exactly when `hcount` lies in [active+front, active+front+sync). Otherwise it is 1.
- R4: `vcount` is the line number within the current field. It advances when a line wraps. It wraps to 0 after the field's last back-porch line. Each field uses its own four vertical settings: field A first, then field B, then field A of the next frame.
- R5: `vsync_n` is 0 for every pixel of the lines whose `vcount` lies in [active+front, active+front+sync) of the current field. Otherwise it is 1.
- R6: `active` is 1 exactly when `hcount` < horizontal active and `vcount` < the current field's active lines.
- R7: `field_odd` is 1 for an odd field. Field A is odd when `cfg_first_odd` is 1 and even when it is 0; field B has the opposite parity. `field_odd` toggles only at the wrap after a field's last back-porch line.
- R8: `burst_win` is 1 for min(`cfg_burst_len`, horizontal back porch) pixels, starting at the first back-porch pixel (active+front+sync). A length of 0 never raises it.
- R9: Setting inputs changed during a frame have no effect until the wrap after the last line of field B. From that wrap on, the new values govern the whole next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, captures settings |
| pix_ce | input | 1 | Pixel enable, one pixel per high cycle |
| cfg_h_active | input | 12 | Active pixels per line |
| cfg_h_front | input | 12 | Horizontal front porch, pixels |
| cfg_h_sync | input | 12 | Horizontal sync width, pixels |
| cfg_h_back | input | 12 | Horizontal back porch, pixels |
| cfg_burst_len | input | 12 | Burst window length, pixels |
| cfg_fa_active | input | 10 | Field A active lines |
| cfg_fa_front | input | 10 | Field A front porch, lines |
| cfg_fa_sync | input | 10 | Field A sync width, lines |
| cfg_fa_back | input | 10 | Field A back porch, lines |
| cfg_fb_active | input | 10 | Field B active lines |
| cfg_fb_front | input | 10 | Field B front porch, lines |
| cfg_fb_sync | input | 10 | Field B sync width, lines |
| cfg_fb_back | input | 10 | Field B back porch, lines |
| cfg_first_odd | input | 1 | 1: field A is the odd field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Active video region |
| field_odd | output | 1 | 1 during an odd field |
| burst_win | output | 1 | Burst window in horizontal back porch |
| hcount | output | 12 | Pixel position in line |
| vcount | output | 10 | Line position in field |

## Verification
Random small raster settings are driven with a random pixel enable. Each output is compared on every cycle against a position model kept by the bench. Dense enable and sparse enable separate a counter that follows `pix_ce` from one that runs freely. Fields with unequal totals and porches show whether the per-field settings are selected by the current field. Settings are changed in the middle of a frame to distinguish capture at the frame boundary from capture at a field or line boundary. Directed settings cover a zero burst length, a burst length longer than the back porch, and both first-field parities, including a second reset.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int HW = 12;
  parameter int VW = 10;
  parameter int NFIELD = 2;

  typedef logic [HW-1:0] hval_t;
  typedef logic [VW-1:0] vval_t;

  typedef struct packed {
    hval_t act;
    hval_t fp;
    hval_t syn;
    hval_t bp;
    hval_t burst;
  } hcfg_t;

  typedef struct packed {
    vval_t act;
    vval_t fp;
    vval_t syn;
    vval_t bp;
  } vcfg_t;

  function automatic hval_t h_total(hcfg_t c);
    return c.act + c.fp + c.syn + c.bp;
  endfunction

  function automatic vval_t v_total(vcfg_t c);
    return c.act + c.fp + c.syn + c.bp;
  endfunction

  // position p inside [s, s+n)
  function automatic logic h_in(hval_t p, hval_t s, hval_t n);
    return (p >= s) && ((p - s) < n);
  endfunction

  function automatic logic v_in(vval_t p, vval_t s, vval_t n);
    return (p >= s) && ((p - s) < n);
  endfunction

  function automatic hval_t burst_span(hcfg_t c);
    return (c.burst < c.bp) ? c.burst : c.bp;
  endfunction
endpackage

// File: rtl/vtg_cfg_shadow.sv
module vtg_cfg_shadow
  import vtg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  hcfg_t                   h_in,
  input  vcfg_t [NFIELD-1:0]      v_in,
  input  logic                    odd_in,
  output hcfg_t                   h_q,
  output vcfg_t [NFIELD-1:0]      v_q,
  output logic                    odd_q
);
  logic cap;
  assign cap = !rst_n || load;

  always_ff @(posedge clk) begin
    if (cap) begin
      h_q   <= h_in;
      odd_q <= odd_in;
    end
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    vcfg_t q;
    always_ff @(posedge clk) begin
      if (cap) q <= v_in[f];
    end
    assign v_q[f] = q;
  end

  // R9: settings change only on a frame wrap
  assert_hold_h_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(h_q));
  assert_hold_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(v_q) && $stable(odd_q)));
endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce,
  input  hcfg_t cfg,
  output hval_t hcnt,
  output logic  line_end,
  output logic  h_act,
  output logic  hsync_n,
  output logic  burst
);
  hval_t tot, sync_start, burst_start;

  assign tot         = h_total(cfg);
  assign sync_start  = cfg.act + cfg.fp;
  assign burst_start = sync_start + cfg.syn;
  assign line_end    = ce && (hcnt == tot - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)        hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else if (ce)       hcnt <= hcnt + 1'b1;
  end

  assign h_act   = hcnt < cfg.act;
  assign hsync_n = !h_in(hcnt, sync_start, cfg.syn);
  assign burst   = h_in(hcnt, burst_start, burst_span(cfg));

  // R2: counter holds without enable, stays inside the line
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(hcnt));
  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < tot);
  // R8: burst window never overlaps sync or active pixels
  assert_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> (hsync_n && !h_act));
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_end,
  input  vcfg_t [NFIELD-1:0]  cfg,
  input  logic                odd_first,
  output vval_t               vcnt,
  output logic                fsel,
  output logic                field_end,
  output logic                frame_wrap,
  output logic                v_act,
  output logic                vsync_n,
  output logic                field_odd
);
  vcfg_t cur;
  vval_t tot;

  assign cur        = cfg[fsel];
  assign tot        = v_total(cur);
  assign field_end  = line_end && (vcnt == tot - 1'b1);
  assign frame_wrap = field_end && fsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt <= '0;
      fsel <= 1'b0;
    end else if (field_end) begin
      vcnt <= '0;
      fsel <= !fsel;
    end else if (line_end) begin
      vcnt <= vcnt + 1'b1;
    end
  end

  assign v_act     = vcnt < cur.act;
  assign vsync_n   = !v_in(vcnt, cur.act + cur.fp, cur.syn);
  assign field_odd = odd_first ^ fsel;

  // R4: line counter stays inside the current field
  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt < tot);
  // R7: parity moves only at a field wrap, and always there
  assert_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (fsel != $past(fsel)));
  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(fsel));
endmodule

// File: rtl/ilace_vtg.sv
module ilace_vtg
  import vtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_ce,
  input  logic [HW-1:0]        cfg_h_active,
  input  logic [HW-1:0]        cfg_h_front,
  input  logic [HW-1:0]        cfg_h_sync,
  input  logic [HW-1:0]        cfg_h_back,
  input  logic [HW-1:0]        cfg_burst_len,
  input  logic [VW-1:0]        cfg_fa_active,
  input  logic [VW-1:0]        cfg_fa_front,
  input  logic [VW-1:0]        cfg_fa_sync,
  input  logic [VW-1:0]        cfg_fa_back,
  input  logic [VW-1:0]        cfg_fb_active,
  input  logic [VW-1:0]        cfg_fb_front,
  input  logic [VW-1:0]        cfg_fb_sync,
  input  logic [VW-1:0]        cfg_fb_back,
  input  logic                 cfg_first_odd,
  output logic                 hsync_n,
  output logic                 vsync_n,
  output logic                 active,
  output logic                 field_odd,
  output logic                 burst_win,
  output logic [HW-1:0]        hcount,
  output logic [VW-1:0]        vcount
);
  hcfg_t              h_in, h_q;
  vcfg_t [NFIELD-1:0] v_in, v_q;
  logic               odd_q;
  logic               line_end, field_end, frame_wrap, fsel;
  logic               h_act, v_act;

  assign h_in = '{act: cfg_h_active, fp: cfg_h_front, syn: cfg_h_sync,
                  bp: cfg_h_back, burst: cfg_burst_len};
  assign v_in[0] = '{act: cfg_fa_active, fp: cfg_fa_front,
                     syn: cfg_fa_sync, bp: cfg_fa_back};
  assign v_in[1] = '{act: cfg_fb_active, fp: cfg_fb_front,
                     syn: cfg_fb_sync, bp: cfg_fb_back};

  vtg_cfg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_wrap),
    .h_in   (h_in),
    .v_in   (v_in),
    .odd_in (cfg_first_odd),
    .h_q    (h_q),
    .v_q    (v_q),
    .odd_q  (odd_q)
  );

  vtg_hcount u_h (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (pix_ce),
    .cfg      (h_q),
    .hcnt     (hcount),
    .line_end (line_end),
    .h_act    (h_act),
    .hsync_n  (hsync_n),
    .burst    (burst_win)
  );

  vtg_vcount u_v (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .cfg        (v_q),
    .odd_first  (odd_q),
    .vcnt       (vcount),
    .fsel       (fsel),
    .field_end  (field_end),
    .frame_wrap (frame_wrap),
    .v_act      (v_act),
    .vsync_n    (vsync_n),
    .field_odd  (field_odd)
  );

  assign active = h_act && v_act;

  // R6: active video never overlaps a sync pulse
  assert_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (hsync_n && vsync_n));
  // R4: a field wrap always coincides with a line wrap to pixel 0
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> (hcount == '0 && vcount == '0));
endmodule

// File: tb/ilace_vtg_tb.sv
module ilace_vtg_tb;
  import vtg_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pix_ce;
  logic hsync_n, vsync_n, active, field_odd, burst_win;
  logic [HW-1:0] hcount;
  logic [VW-1:0] vcount;

  // settings on the inputs
  int ha, hf, hs, hb, bl, fo;
  int va[2], vf[2], vs[2], vb[2];
  // settings the model holds for the running frame
  int kha, khf, khs, khb, kbl, kfo;
  int kva[2], kvf[2], kvs[2], kvb[2];
  // model position
  int mh, mv, mf;
  int n_chk = 0, n_bad = 0;

  ilace_vtg u_dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .cfg_h_active(HW'(ha)), .cfg_h_front(HW'(hf)), .cfg_h_sync(HW'(hs)),
    .cfg_h_back(HW'(hb)), .cfg_burst_len(HW'(bl)),
    .cfg_fa_active(VW'(va[0])), .cfg_fa_front(VW'(vf[0])),
    .cfg_fa_sync(VW'(vs[0])), .cfg_fa_back(VW'(vb[0])),
    .cfg_fb_active(VW'(va[1])), .cfg_fb_front(VW'(vf[1])),
    .cfg_fb_sync(VW'(vs[1])), .cfg_fb_back(VW'(vb[1])),
    .cfg_first_odd(fo[0]),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active),
    .field_odd(field_odd), .burst_win(burst_win),
    .hcount(hcount), .vcount(vcount)
  );

  task automatic chk(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d f=%0d)",
               tag, nm, act, exp, mh, mv, mf);
    end
  endtask

  task automatic take_inputs();
    kha = ha; khf = hf; khs = hs; khb = hb; kbl = bl; kfo = fo;
    for (int f = 0; f < 2; f++) begin
      kva[f] = va[f]; kvf[f] = vf[f]; kvs[f] = vs[f]; kvb[f] = vb[f];
    end
  endtask

  function automatic bit pending();
    bit d = (ha != kha) || (hf != khf) || (hs != khs) || (hb != khb) ||
            (bl != kbl) || (fo != kfo);
    for (int f = 0; f < 2; f++)
      d = d || (va[f] != kva[f]) || (vf[f] != kvf[f]) ||
               (vs[f] != kvs[f]) || (vb[f] != kvb[f]);
    return d;
  endfunction

  function automatic bit span(int p, int s, int n);
    return (p >= s) && (p < s + n);
  endfunction

  task automatic advance();
    mh++;
    if (mh == kha + khf + khs + khb) begin
      mh = 0;
      mv++;
      if (mv == kva[mf] + kvf[mf] + kvs[mf] + kvb[mf]) begin
        mv = 0;
        if (mf == 1) begin
          mf = 0;
          take_inputs();
        end else mf = 1;
      end
    end
  endtask

  task automatic compare_all();
    bit p = pending();
    int blen = (kbl < khb) ? kbl : khb;
    chk(p ? "R9" : "R2", "hcount", int'(hcount), mh);
    chk(p ? "R9" : "R4", "vcount", int'(vcount), mv);
    chk(p ? "R9" : "R3", "hsync_n", int'(hsync_n),
        span(mh, kha + khf, khs) ? 0 : 1);
    chk(p ? "R9" : "R5", "vsync_n", int'(vsync_n),
        span(mv, kva[mf] + kvf[mf], kvs[mf]) ? 0 : 1);
    chk(p ? "R9" : "R6", "active", int'(active),
        (mh < kha && mv < kva[mf]) ? 1 : 0);
    chk(p ? "R9" : "R7", "field_odd", int'(field_odd), kfo ^ mf);
    chk(p ? "R9" : "R8", "burst_win", int'(burst_win),
        span(mh, kha + khf + khs, blen) ? 1 : 0);
  endtask

  task automatic step(int ce_pct);
    @(negedge clk);
    if (pix_ce) advance();
    compare_all();
    pix_ce = (($urandom % 100) < ce_pct);
  endtask

  task automatic run(int cycles, int ce_pct);
    for (int i = 0; i < cycles; i++) step(ce_pct);
  endtask

  task automatic rand_cfg();
    ha = 1 + $urandom % 8; hf = 1 + $urandom % 3; hs = 1 + $urandom % 3;
    hb = 1 + $urandom % 5; bl = $urandom % 7;     fo = $urandom % 2;
    for (int f = 0; f < 2; f++) begin
      va[f] = 1 + $urandom % 5; vf[f] = 1 + $urandom % 3;
      vs[f] = 1 + $urandom % 3; vb[f] = 1 + $urandom % 3;
    end
  endtask

  function automatic int frame_px();
    return (ha + hf + hs + hb) *
           (va[0] + vf[0] + vs[0] + vb[0] + va[1] + vf[1] + vs[1] + vb[1]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_ce = 1'b0;
    repeat (3) @(negedge clk);
    take_inputs(); mh = 0; mv = 0; mf = 0;
    // R1: reset state
    chk("R1", "hcount", int'(hcount), 0);
    chk("R1", "vcount", int'(vcount), 0);
    chk("R1", "hsync_n", int'(hsync_n), 1);
    chk("R1", "field_odd", int'(field_odd), fo);
    chk("R1", "active", int'(active), 1);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pix_ce = 1'b0;
    // directed: small NTSC-like shape, odd first, burst longer than back porch
    ha = 6; hf = 1; hs = 2; hb = 3; bl = 5; fo = 1;
    va[0] = 4; vf[0] = 1; vs[0] = 1; vb[0] = 2;
    va[1] = 3; vf[1] = 1; vs[1] = 1; vb[1] = 2;
    do_reset();
    run(2 * frame_px() + 20, 100);   // R2 R3 R4 R5 R6 R7 R8 dense enable
    run(frame_px(), 20);             // R2 sparse enable holds counters

    // directed: PAL-like shape, even first, zero burst (R8)
    ha = 7; hf = 2; hs = 2; hb = 3; bl = 0; fo = 0;
    va[0] = 4; vf[0] = 1; vs[0] = 1; vb[0] = 3;
    va[1] = 4; vf[1] = 1; vs[1] = 1; vb[1] = 2;
    do_reset();
    run(2 * frame_px() + 30, 80);

    // random settings, changed mid-frame (R9)
    for (int n = 0; n < 12; n++) begin
      rand_cfg();
      run(2 * frame_px(), 75);
      rand_cfg();                    // change inside a running frame
      run(frame_px() / 2 + 5, 75);
    end
    // second reset with random settings (R1)
    rand_cfg();
    do_reset();
    run(frame_px() + 10, 60);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule